// File: doc/BRIEF.md
# Quantization Table Upload Sequencer

This block moves the two 64-byte quantization tables of an image compressor, one for luma and one for chroma, from a local table memory into the compressor's 16-bit register file. A single start pulse launches the transfer. The block then writes one register per clock cycle with no gaps. It turns on the compression clock first. Next it writes the table words, with luma and chroma interleaved. Last it enables the encoder. One cycle after the last register write, it raises a done pulse.

The table memory has a synchronous read port with one cycle of latency. Each read returns one byte pair. The sequencer issues the read for the next pair one cycle ahead, so the write stream never stalls. Each pair becomes one little-endian register word. The table contents are produced elsewhere and must already be in the memory before start is pulsed.

Top module: `qtu_upload_seq`

## Requirements
- R1: After reset, `wr_en`, `done` and `mem_ren` are low.
- R2: The first write appears in the cycle after the edge that samples `start` with the block idle. It writes value 0x0010 to register 0x39, which turns on the compression clock.
- R3: Writes 1 to 64 carry the tables. Write 2i+1 goes to register 0x40+i (luma, iteration i). Write 2i+2 goes to register 0x60+i (chroma). So within each iteration, luma comes before chroma.
- R4: Each table word is little-endian. The byte at even table index 2i is the low byte of the word. The byte at odd index 2i+1 is the high byte. Each memory read returns the even byte in `mem_rdata[15:8]` and the odd byte in `mem_rdata[7:0]`.
- R5: The memory read address is `{table_sel, pair}`, where table_sel 0 selects luma, 1 selects chroma, and `pair` is i. Read data is valid one cycle after `mem_ren`. All 66 writes occur on 66 consecutive cycles.
- R6: Write 65, the last one, puts value 0x0012 into register 0x39 to enable the encoder.
- R7: `done` is high for exactly one cycle, the cycle after the final write, and `wr_en` is low in that cycle.
- R8: A start pulse that arrives while a transfer is running, including during the cycle of the final write, is ignored. The write stream and its length do not change, and no new transfer follows.
- R9: A start pulse that arrives in the cycle where `done` is high begins a new transfer. Its first write appears in the next cycle.
- R10: While idle with `start` low, the block issues no register writes and no memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an upload |
| mem_ren | output | 1 | Table memory read enable |
| mem_raddr | output | 6 | Table memory pair address {table_sel, pair} |
| mem_rdata | input | 16 | Byte pair from memory, even byte in the upper lane |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register address |
| wr_data | output | 16 | Register write value |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result has a fixed latency from the edge that accepts start:
- write j is visible j+1 cycles after the start is driven;
- `done` is visible one cycle after write 65.

The bench drives stimulus and samples outputs only on falling clock edges. It steps through the transfer one falling edge per write and compares the address and data of each write against values computed from the byte formula of its memory model. For the cases where start must be ignored, the bench confirms that the next cycles show exactly the remaining writes of the stream, then `done`, then silence. For the back-to-back case, it expects the clock-enable write in the cycle right after `done`.

// File: rtl/qtu_pkg.sv
package qtu_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HEAD  = 2'd1,
    PH_TABLE = 2'd2,
    PH_TAIL  = 2'd3
  } qtu_phase_e;

  localparam int unsigned QTU_LANES = 2;

endpackage

// File: rtl/qtu_step_ctrl.sv
module qtu_step_ctrl #(
  parameter int unsigned PAIRS  = 32,
  parameter int unsigned STEP_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  output logic                   accept,
  output logic                   busy,
  output logic [STEP_W-1:0]      step,
  output qtu_pkg::qtu_phase_e    phase,
  output logic                   done
);
  import qtu_pkg::*;

  localparam int unsigned TABLE_WRITES = 2 * PAIRS;
  localparam int unsigned TOTAL        = TABLE_WRITES + 2;

  assign accept = start && !busy;

  always_comb begin
    if (accept)
      phase = PH_HEAD;
    else if (busy && step >= STEP_W'(1) && step <= STEP_W'(TABLE_WRITES))
      phase = PH_TABLE;
    else if (busy && step == STEP_W'(TABLE_WRITES + 1))
      phase = PH_TAIL;
    else
      phase = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        step <= STEP_W'(1);
      end else if (busy) begin
        if (step == STEP_W'(TOTAL)) begin
          busy <= 1'b0;
          step <= '0;
          done <= 1'b1;
        end else begin
          step <= step + STEP_W'(1);
        end
      end
    end
  end

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: done only closes a running transfer
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R8: a running transfer advances one step per cycle regardless of start
  a_r8_steady_advance: assert property (@(posedge clk) disable iff (rst)
    (busy && step != STEP_W'(TOTAL)) |=> (busy && step == $past(step) + STEP_W'(1)));

endmodule

// File: rtl/qtu_read_gen.sv
module qtu_read_gen #(
  parameter int unsigned PAIRS  = 32,
  parameter int unsigned STEP_W = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          accept,
  input  logic                          busy,
  input  logic [STEP_W-1:0]             step,
  output logic                          mem_ren,
  output logic [$clog2(PAIRS):0]        mem_raddr
);
  localparam int unsigned PAIR_W       = $clog2(PAIRS);
  localparam int unsigned TABLE_WRITES = 2 * PAIRS;

  logic [STEP_W-1:0] rd_idx;
  logic [PAIR_W-1:0] pair;

  // read k feeds table write k+1; read 0 is issued in the accepting cycle
  assign rd_idx    = accept ? '0 : step;
  assign pair      = PAIR_W'(rd_idx >> 1);
  assign mem_ren   = accept || (busy && step < STEP_W'(TABLE_WRITES));
  assign mem_raddr = {rd_idx[0], pair};

  // R5: reads only happen in the accepting cycle or inside a transfer
  a_r5_read_in_window: assert property (@(posedge clk) disable iff (rst)
    mem_ren |-> (accept || busy));

endmodule

// File: rtl/qtu_word_pack.sv
module qtu_word_pack #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [qtu_pkg::QTU_LANES*BYTE_W-1:0] pair_in,
  output logic [qtu_pkg::QTU_LANES*BYTE_W-1:0] word_out
);
  localparam int unsigned LANES = qtu_pkg::QTU_LANES;

  // memory holds the even byte in the top lane; the register wants it low
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign word_out[ln*BYTE_W +: BYTE_W] = pair_in[(LANES-1-ln)*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/qtu_reg_writer.sv
module qtu_reg_writer #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned PAIRS       = 32,
  parameter int unsigned REG_AW      = 8,
  parameter int unsigned STEP_W      = 7,
  parameter int unsigned CTRL_ADDR   = 'h39,
  parameter int unsigned CLK_EN_VAL  = 'h0010,
  parameter int unsigned ENC_EN_VAL  = 'h0012,
  parameter int unsigned LUMA_BASE   = 'h40,
  parameter int unsigned CHROMA_BASE = 'h60
) (
  input  logic                      clk,
  input  logic                      rst,
  input  qtu_pkg::qtu_phase_e       phase,
  input  logic [STEP_W-1:0]         step,
  input  logic [2*BYTE_W-1:0]       word,
  output logic                      wr_en,
  output logic [REG_AW-1:0]         wr_addr,
  output logic [2*BYTE_W-1:0]       wr_data
);
  import qtu_pkg::*;

  localparam int unsigned REG_DW = 2 * BYTE_W;
  localparam int unsigned PAIR_W = $clog2(PAIRS);

  logic [STEP_W-1:0] tbl_k;
  logic [PAIR_W-1:0] iter;
  logic [REG_AW-1:0] tbl_addr;

  assign tbl_k    = step - STEP_W'(1);
  assign iter     = PAIR_W'(tbl_k >> 1);
  assign tbl_addr = (tbl_k[0] ? REG_AW'(CHROMA_BASE) : REG_AW'(LUMA_BASE)) + REG_AW'(iter);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      unique case (phase)
        PH_HEAD: begin
          wr_en   <= 1'b1;
          wr_addr <= REG_AW'(CTRL_ADDR);
          wr_data <= REG_DW'(CLK_EN_VAL);
        end
        PH_TABLE: begin
          wr_en   <= 1'b1;
          wr_addr <= tbl_addr;
          wr_data <= word;
        end
        PH_TAIL: begin
          wr_en   <= 1'b1;
          wr_addr <= REG_AW'(CTRL_ADDR);
          wr_data <= REG_DW'(ENC_EN_VAL);
        end
        default: begin
          wr_en   <= 1'b0;
        end
      endcase
    end
  end

  // R2, R6: the control register only ever receives the two enable values
  a_r2_ctrl_values: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_AW'(CTRL_ADDR)) |->
      (wr_data == REG_DW'(CLK_EN_VAL) || wr_data == REG_DW'(ENC_EN_VAL)));

  // R3: table writes land in the luma or chroma block
  a_r3_table_range: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != REG_AW'(CTRL_ADDR)) |->
      ((wr_addr >= REG_AW'(LUMA_BASE) && wr_addr < REG_AW'(LUMA_BASE + PAIRS)) ||
       (wr_addr >= REG_AW'(CHROMA_BASE) && wr_addr < REG_AW'(CHROMA_BASE + PAIRS))));

  // R5: a table write is always followed by another write
  a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != REG_AW'(CTRL_ADDR)) |=> wr_en);

endmodule

// File: rtl/qtu_upload_seq.sv
module qtu_upload_seq #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned PAIRS       = 32,
  parameter int unsigned REG_AW      = 8,
  parameter int unsigned CTRL_ADDR   = 'h39,
  parameter int unsigned CLK_EN_VAL  = 'h0010,
  parameter int unsigned ENC_EN_VAL  = 'h0012,
  parameter int unsigned LUMA_BASE   = 'h40,
  parameter int unsigned CHROMA_BASE = 'h60
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  output logic                       mem_ren,
  output logic [$clog2(PAIRS):0]     mem_raddr,
  input  logic [2*BYTE_W-1:0]        mem_rdata,
  output logic                       wr_en,
  output logic [REG_AW-1:0]          wr_addr,
  output logic [2*BYTE_W-1:0]        wr_data,
  output logic                       done
);
  import qtu_pkg::*;

  localparam int unsigned REG_DW = 2 * BYTE_W;
  localparam int unsigned TOTAL  = 2 * PAIRS + 2;
  localparam int unsigned STEP_W = $clog2(TOTAL + 1);

  logic              accept;
  logic              busy;
  logic [STEP_W-1:0] step;
  qtu_phase_e        phase;
  logic [REG_DW-1:0] packed_word;

  qtu_step_ctrl #(.PAIRS(PAIRS), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .accept(accept), .busy(busy),
    .step(step), .phase(phase), .done(done)
  );

  qtu_read_gen #(.PAIRS(PAIRS), .STEP_W(STEP_W)) u_rd (
    .clk(clk), .rst(rst), .accept(accept), .busy(busy), .step(step),
    .mem_ren(mem_ren), .mem_raddr(mem_raddr)
  );

  qtu_word_pack #(.BYTE_W(BYTE_W)) u_pack (
    .pair_in(mem_rdata), .word_out(packed_word)
  );

  qtu_reg_writer #(
    .BYTE_W(BYTE_W), .PAIRS(PAIRS), .REG_AW(REG_AW), .STEP_W(STEP_W),
    .CTRL_ADDR(CTRL_ADDR), .CLK_EN_VAL(CLK_EN_VAL), .ENC_EN_VAL(ENC_EN_VAL),
    .LUMA_BASE(LUMA_BASE), .CHROMA_BASE(CHROMA_BASE)
  ) u_wr (
    .clk(clk), .rst(rst), .phase(phase), .step(step), .word(packed_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // R6, R7: the encoder-enable write is followed by done
  a_r6_done_follows_enc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_AW'(CTRL_ADDR) && wr_data == REG_DW'(ENC_EN_VAL)) |=> done);

  // R7: no write in the done cycle
  a_r7_quiet_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);

endmodule

// File: tb/tb_qtu_upload_seq.sv
module tb_qtu_upload_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        mem_ren;
  logic [5:0]  mem_raddr;
  logic [15:0] mem_rdata;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        done;

  int checks = 0;
  int errors = 0;
  int seed   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  qtu_upload_seq dut (
    .clk(clk), .rst(rst), .start(start), .mem_ren(mem_ren),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  function automatic logic [7:0] tbyte(int sd, logic sel, int b);
    return 8'((b * (2 * sd + 3) + sd * 37 + (sel ? 90 : 0)) & 255);
  endfunction

  // memory model: even byte in the upper lane (R4), address {sel, pair} (R5)
  always_ff @(posedge clk) begin
    if (mem_ren)
      mem_rdata <= {tbyte(seed, mem_raddr[5], 2 * int'(mem_raddr[4:0])),
                    tbyte(seed, mem_raddr[5], 2 * int'(mem_raddr[4:0]) + 1)};
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_write(int j, int sd);
    int k, i;
    logic [7:0]  ea;
    logic [15:0] ed;
    check(wr_en == 1'b1, "R5 wr_en each cycle", 32'(wr_en), 1);
    check(done == 1'b0, "R7 done low during writes", 32'(done), 0);
    if (j == 0) begin
      ea = 8'h39; ed = 16'h0010;
      check(wr_addr == ea && wr_data == ed, "R2 clock enable write",
            {8'h0, wr_addr, wr_data}, {8'h0, ea, ed});
    end else if (j == 65) begin
      ea = 8'h39; ed = 16'h0012;
      check(wr_addr == ea && wr_data == ed, "R6 encoder enable write",
            {8'h0, wr_addr, wr_data}, {8'h0, ea, ed});
    end else begin
      k  = j - 1;
      i  = k / 2;
      ea = 8'((k % 2 == 1) ? 'h60 + i : 'h40 + i);
      ed = {tbyte(sd, k[0], 2 * i + 1), tbyte(sd, k[0], 2 * i)};
      check(wr_addr == ea, "R3 table address order", 32'(wr_addr), 32'(ea));
      check(wr_data == ed, "R4 little-endian word", 32'(wr_data), 32'(ed));
    end
  endtask

  // restart_at: index of the write during which start is raised again (-1 none)
  task automatic run_upload(int sd, int restart_at, bit chain);
    seed = sd;
    @(negedge clk);
    start = 1'b1;
    for (int j = 0; j < 66; j++) begin
      @(negedge clk);
      start = (j == restart_at);
      check_write(j, sd);
    end
    @(negedge clk);
    start = chain;
    check(done == 1'b1, "R7 done after final write", 32'(done), 1);
    check(wr_en == 1'b0, "R7 no write in done cycle", 32'(wr_en), 0);
    if (chain) begin
      @(negedge clk);
      start = 1'b0;
      check(wr_en && wr_addr == 8'h39 && wr_data == 16'h0010, "R9 restart in done cycle",
            {8'h0, wr_addr, wr_data}, {8'h0, 8'h39, 16'h0010});
      for (int j = 1; j < 66; j++) begin
        @(negedge clk);
        check_write(j, sd);
      end
      @(negedge clk);
      check(done == 1'b1, "R9 chained run completes", 32'(done), 1);
    end
    for (int q = 0; q < 3; q++) begin
      @(negedge clk);
      check(wr_en == 1'b0 && done == 1'b0, "R8 no extra transfer",
            {30'h0, wr_en, done}, 0);
    end
  endtask

  initial begin
    rst   = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wr_en == 1'b0 && done == 1'b0 && mem_ren == 1'b0, "R1 reset state",
          {29'h0, wr_en, done, mem_ren}, 0);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      check(wr_en == 1'b0 && mem_ren == 1'b0, "R10 idle quiet",
            {30'h0, wr_en, mem_ren}, 0);
    end
    run_upload(0, -1, 1'b0);
    run_upload(3, 0, 1'b0);
    run_upload(7, 30, 1'b0);
    run_upload(11, 65, 1'b0);
    run_upload(2, -1, 1'b1);
    run_upload(13, 64, 1'b0);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      check(wr_en == 1'b0 && mem_ren == 1'b0, "R10 idle quiet after runs",
            {30'h0, wr_en, mem_ren}, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule